// File: doc/BRIEF.md
# Microcode Control Sequencer

This block generates the control signals of a multicycle processor from a stored microprogram instead of a hard-wired state machine. A microprogram counter addresses a 22-bit microinstruction store. Each microinstruction carries the control microorders for the current step and a 2-bit sequence code that picks the next microaddress. The next microaddress is one of four things: the current address plus one, an entry from either of two dispatch tables indexed by the instruction opcode, or address 0.

Address 0 is the fetch step and address 1 is the decode step. The first dispatch table does the multiway branch out of decode into the handler for each instruction class. The second table splits the shared memory-address step into the load path or the store path. The microprogram and both tables are computed constants inside the block. The datapath that consumes the control fields is outside this block.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, `upc` is 0. When reset is released, `upc` stays 0 until the next rising clock edge.
- R2: A microinstruction whose sequence code (bits [1:0] of the word, seen on `seq_sel`) is 00 moves `upc` to `upc`+1 on the next edge. The codes per address are: 0→00, 1→01, 2→10, 3→00, 7→00, and 4, 5, 6, 8→11.
- R3: Sequence code 01 (at address 1) loads `upc` from dispatch table 1. ALU opcodes (0x00 and 0x08–0x0F) go to 7. Load (0x20) and store (0x28) go to 2. Flow-control opcodes (0x01–0x05) go to 5.
- R4: Sequence code 10 (at address 2) loads `upc` from dispatch table 2. Load goes to 3 and store goes to 6.
- R5: Sequence code 11 returns `upc` to 0 on the next edge.
- R6: An opcode with no entry in the table being used sends `upc` to 0. This includes any opcode outside the classes above at decode, and any non-memory opcode at address 2.
- R7: Address 0 asserts `mem_rd`, `ir_wr` and `pc_wr`. Address 3 asserts `mem_rd`. `mem_wr` is 1 only at address 6. `reg_wr` is 1 only at addresses 4 and 8. `mem_rd` and `mem_wr` are never both 1.
- R8: The microaddress traces are ALU 0,1,7,8; load 0,1,2,3,4; store 0,1,2,6; flow control 0,1,5. Each instruction takes 3 to 5 microinstructions.
- R9: The opcode is used only at addresses 1 and 2. Changing it at any other address has no effect on the trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OPW (6) | Opcode of the instruction being executed |
| upc | output | AW (5) | Current microaddress |
| seq_sel | output | 2 | Sequence code of the current microinstruction |
| jmp_sel | output | 1 | Jump-address source select |
| pc_src | output | 2 | Program-counter source select |
| pc_wr | output | 1 | Program-counter write |
| inst_dat | output | 1 | Memory address from instruction (0) or data (1) path |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| reg_dst | output | 2 | Destination register select |
| reg_in | output | 2 | Register write-data select |
| reg_wr | output | 1 | Register file write |
| alu_x | output | 1 | ALU first operand select |
| alu_y | output | 2 | ALU second operand select |
| alu_fn | output | 4 | ALU function code |

## Verification
The bench walks every instruction class through the microprogram, including a second ALU opcode taken from the immediate range. If a dispatch table entry is swapped, that class enters the wrong handler and its trace shows a foreign address. A wrong sequence code on one word either skips a step or never returns to fetch.

An undefined opcode at decode must fall back to fetch after two steps; a design that defaults to address 1 or 2 would loop or touch memory. Changing the opcode at address 2 checks the second table's fallback. Changing it at address 7 catches a design that reads the opcode outside the dispatch steps. Every trace step also compares the memory and register write strobes, so a microorder landing on the wrong word is caught.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SQ_NEXT = 2'b00,
    SQ_D1   = 2'b01,
    SQ_D2   = 2'b10,
    SQ_HOME = 2'b11
  } seq_e;

  typedef struct packed {
    logic       jmp_sel;
    logic [1:0] pc_src;
    logic       pc_wr;
    logic       inst_dat;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic [1:0] reg_dst;
    logic [1:0] reg_in;
    logic       reg_wr;
    logic       alu_x;
    logic [1:0] alu_y;
    logic [3:0] alu_fn;
    seq_e       seq;
  } uword_t;

  localparam int UW = $bits(uword_t);

  typedef enum logic [2:0] {
    CL_NONE, CL_ALU, CL_LOAD, CL_STORE, CL_FLOW
  } iclass_e;

  // microprogram addresses
  localparam int A_FETCH = 0;
  localparam int A_DECOD = 1;
  localparam int A_MADDR = 2;
  localparam int A_MREAD = 3;
  localparam int A_LDWB  = 4;
  localparam int A_FLOW  = 5;
  localparam int A_STORE = 6;
  localparam int A_EXEC  = 7;
  localparam int A_ALUWB = 8;

  localparam logic [3:0] FN_ADD  = 4'b0001;
  localparam logic [3:0] FN_SUB  = 4'b0010;
  localparam logic [3:0] FN_FUNC = 4'b1111;

  function automatic iclass_e classify(input int unsigned v);
    if (v == 0 || (v >= 8 && v <= 15)) return CL_ALU;
    if (v == 32)                        return CL_LOAD;
    if (v == 40)                        return CL_STORE;
    if (v >= 1 && v <= 5)               return CL_FLOW;
    return CL_NONE;
  endfunction

  // tbl 0: branch out of decode, tbl 1: branch out of memory-address step
  function automatic int unsigned dispatch_target(input int tbl, input iclass_e c);
    if (tbl == 0) begin
      case (c)
        CL_ALU:            return A_EXEC;
        CL_LOAD, CL_STORE: return A_MADDR;
        CL_FLOW:           return A_FLOW;
        default:           return A_FETCH;
      endcase
    end
    case (c)
      CL_LOAD:  return A_MREAD;
      CL_STORE: return A_STORE;
      default:  return A_FETCH;
    endcase
  endfunction

  function automatic uword_t rom_word(input int unsigned a);
    uword_t w;
    w = '0;
    case (a)
      A_FETCH: begin
        w.mem_rd = 1'b1; w.ir_wr = 1'b1; w.alu_y = 2'b01;
        w.alu_fn = FN_ADD; w.pc_src = 2'b11; w.pc_wr = 1'b1; w.seq = SQ_NEXT;
      end
      A_DECOD: begin
        w.alu_y = 2'b11; w.alu_fn = FN_ADD; w.seq = SQ_D1;
      end
      A_MADDR: begin
        w.alu_x = 1'b1; w.alu_y = 2'b10; w.alu_fn = FN_ADD; w.seq = SQ_D2;
      end
      A_MREAD: begin
        w.inst_dat = 1'b1; w.mem_rd = 1'b1; w.seq = SQ_NEXT;
      end
      A_LDWB: begin
        w.reg_wr = 1'b1; w.seq = SQ_HOME;
      end
      A_FLOW: begin
        w.alu_x = 1'b1; w.alu_fn = FN_SUB; w.pc_src = 2'b01;
        w.pc_wr = 1'b1; w.jmp_sel = 1'b1; w.seq = SQ_HOME;
      end
      A_STORE: begin
        w.inst_dat = 1'b1; w.mem_wr = 1'b1; w.seq = SQ_HOME;
      end
      A_EXEC: begin
        w.alu_x = 1'b1; w.alu_fn = FN_FUNC; w.seq = SQ_NEXT;
      end
      A_ALUWB: begin
        w.reg_dst = 2'b01; w.reg_in = 2'b01; w.reg_wr = 1'b1; w.seq = SQ_HOME;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  localparam int PADW = 32 - AW;

  always_comb word = rom_word({{PADW{1'b0}}, addr});
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int AW  = 5,
  parameter int OPW = 6,
  parameter int TBL = 0
) (
  input  logic [OPW-1:0] op,
  output logic [AW-1:0]  tgt
);
  localparam int PADW = 32 - OPW;

  iclass_e cls;
  always_comb cls = classify({{PADW{1'b0}}, op});

  if (TBL == 0) begin : g_after_decode
    always_comb tgt = AW'(dispatch_target(0, cls));
  end else begin : g_after_maddr
    always_comb tgt = AW'(dispatch_target(1, cls));
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = 5
) (
  input  seq_e          seq,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] d1,
  input  logic [AW-1:0] d2,
  output logic [AW-1:0] nxt
);
  always_comb begin
    case (seq)
      SQ_NEXT: nxt = cur + AW'(1);
      SQ_D1:   nxt = d1;
      SQ_D2:   nxt = d2;
      default: nxt = '0;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int AW  = 5,
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  upc,
  output logic [1:0]     seq_sel,
  output logic           jmp_sel,
  output logic [1:0]     pc_src,
  output logic           pc_wr,
  output logic           inst_dat,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_wr,
  output logic [1:0]     reg_dst,
  output logic [1:0]     reg_in,
  output logic           reg_wr,
  output logic           alu_x,
  output logic [1:0]     alu_y,
  output logic [3:0]     alu_fn
);
  localparam int NTBL = 2;

  uword_t        cur_word;
  logic [AW-1:0] disp_tgt [NTBL];
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] upc_q;

  useq_rom #(.AW(AW)) u_rom (.addr(upc_q), .word(cur_word));

  for (genvar g = 0; g < NTBL; g++) begin : g_tbl
    useq_dispatch #(.AW(AW), .OPW(OPW), .TBL(g)) u_tbl (
      .op  (opcode),
      .tgt (disp_tgt[g])
    );
  end

  useq_next #(.AW(AW)) u_next (
    .seq (cur_word.seq),
    .cur (upc_q),
    .d1  (disp_tgt[0]),
    .d2  (disp_tgt[1]),
    .nxt (nxt_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= nxt_addr;
  end

  assign upc      = upc_q;
  assign seq_sel  = cur_word.seq;
  assign jmp_sel  = cur_word.jmp_sel;
  assign pc_src   = cur_word.pc_src;
  assign pc_wr    = cur_word.pc_wr;
  assign inst_dat = cur_word.inst_dat;
  assign mem_rd   = cur_word.mem_rd;
  assign mem_wr   = cur_word.mem_wr;
  assign ir_wr    = cur_word.ir_wr;
  assign reg_dst  = cur_word.reg_dst;
  assign reg_in   = cur_word.reg_in;
  assign reg_wr   = cur_word.reg_wr;
  assign alu_x    = cur_word.alu_x;
  assign alu_y    = cur_word.alu_y;
  assign alu_fn   = cur_word.alu_fn;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] upc,
  input logic [1:0]    seq_sel,
  input logic          mem_rd,
  input logic          mem_wr
);
  // R1
  a_r1_reset_home: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> upc == '0);

  // R2
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    seq_sel == 2'b00 |=> upc == $past(upc) + AW'(1));

  // R3
  a_r3_decode_targets: assert property (@(posedge clk) disable iff (!rst_n)
    seq_sel == 2'b01 |=> (upc == AW'(0) || upc == AW'(2) || upc == AW'(5) || upc == AW'(7)));

  // R4
  a_r4_maddr_targets: assert property (@(posedge clk) disable iff (!rst_n)
    seq_sel == 2'b10 |=> (upc == AW'(0) || upc == AW'(3) || upc == AW'(6)));

  // R5
  a_r5_return_home: assert property (@(posedge clk) disable iff (!rst_n)
    seq_sel == 2'b11 |=> upc == '0);

  // R7
  a_r7_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));
endmodule

bind useq_core useq_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .upc     (upc),
  .seq_sel (seq_sel),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr)
);

// File: tb/sim_useq_core.sv
`timescale 1ns/1ps
module sim_useq_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [4:0] upc;
  logic [1:0] seq_sel, pc_src, reg_dst, reg_in, alu_y;
  logic       jmp_sel, pc_wr, inst_dat, mem_rd, mem_wr, ir_wr, reg_wr, alu_x;
  logic [3:0] alu_fn;

  int nvec = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  useq_core u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc), .seq_sel(seq_sel),
    .jmp_sel(jmp_sel), .pc_src(pc_src), .pc_wr(pc_wr), .inst_dat(inst_dat),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_dst(reg_dst),
    .reg_in(reg_in), .reg_wr(reg_wr), .alu_x(alu_x), .alu_y(alu_y), .alu_fn(alu_fn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // sequence code expected at each microaddress (R2 table)
  function automatic int exp_seq(input int a);
    case (a)
      1:       return 1;
      2:       return 2;
      0, 3, 7: return 0;
      default: return 3;
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 upc in reset", upc, 0);
    rst_n = 1'b1;
    #1;
    chk("R1 upc after release", upc, 0);
    chk("R7 fetch mem_rd", mem_rd, 1);
    chk("R7 fetch ir_wr", ir_wr, 1);
    chk("R7 fetch pc_wr", pc_wr, 1);
  endtask

  // walk one instruction; optionally change opcode when swap_at is reached
  task automatic run_instr(input string tag, input logic [5:0] op, input int n,
                           input int ex[5], input int swap_at, input logic [5:0] swap_op);
    @(negedge clk);
    while (upc != 0) @(negedge clk);
    opcode = op;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      chk({tag, " R8 trace"}, upc, ex[k]);
      chk({tag, " R2 seq code"}, seq_sel, exp_seq(ex[k]));
      chk({tag, " R7 mem_wr"}, mem_wr, (ex[k] == 6) ? 1 : 0);
      chk({tag, " R7 reg_wr"}, reg_wr, (ex[k] == 4 || ex[k] == 8) ? 1 : 0);
      chk({tag, " R7 mem_rd"}, mem_rd, (ex[k] == 0 || ex[k] == 3) ? 1 : 0);
      if (ex[k] == swap_at) opcode = swap_op;
    end
    @(negedge clk);
    chk({tag, " R5 back to fetch"}, upc, 0);
  endtask

  task automatic t_alu();
    run_instr("R3 alu reg", 6'h00, 4, '{0, 1, 7, 8, 0}, -1, 6'h00);
    run_instr("R3 alu imm", 6'h0B, 4, '{0, 1, 7, 8, 0}, -1, 6'h00);
  endtask

  task automatic t_load();
    run_instr("R4 load", 6'h20, 5, '{0, 1, 2, 3, 4}, -1, 6'h00);
  endtask

  task automatic t_store();
    run_instr("R4 store", 6'h28, 4, '{0, 1, 2, 6, 0}, -1, 6'h00);
  endtask

  task automatic t_flow();
    run_instr("R3 flow", 6'h03, 3, '{0, 1, 5, 0, 0}, -1, 6'h00);
    run_instr("R3 flow edge", 6'h05, 3, '{0, 1, 5, 0, 0}, -1, 6'h00);
  endtask

  task automatic t_unknown();
    run_instr("R6 undefined at decode", 6'h3F, 2, '{0, 1, 0, 0, 0}, -1, 6'h00);
    run_instr("R6 undefined 0x06", 6'h06, 2, '{0, 1, 0, 0, 0}, -1, 6'h00);
  endtask

  task automatic t_table2_miss();
    run_instr("R6 alu at maddr", 6'h20, 3, '{0, 1, 2, 0, 0}, 2, 6'h00);
  endtask

  task automatic t_ignore();
    run_instr("R9 change at exec", 6'h00, 4, '{0, 1, 7, 8, 0}, 7, 6'h20);
    run_instr("R9 change at mread", 6'h20, 5, '{0, 1, 2, 3, 4}, 3, 6'h28);
  endtask

  initial begin
    #(5.0 * 200000);
    nbad++;
    $display("FAIL watchdog: got 0 expected 1 completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_load();
    t_store();
    t_flow();
    t_unknown();
    t_table2_miss();
    t_ignore();
    t_reset();
    t_load();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule